// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block is the host side of a link to a 16-bit sampling converter. The converter runs with an externally supplied data clock, and that clock toggles only while a word is being read. A single start request, together with a 2-bit channel number, runs one full transaction. The block first puts the channel on the address lines and strobes it into the converter's input multiplexer. It then pulses the read/convert line low with chip select low to start a conversion. It then produces a burst of data-clock pulses and shifts the returned bits into a word, most significant bit first.

Two mode inputs are sampled together with the start request. One chooses which result the burst reads:
- the result of the conversion just started, fetched once BUSY has gone high again, or
- the previous result, fetched at the start of the conversion, while BUSY is low.

The other chooses whether an arming pulse is sent while read/convert is still low. When this arming pulse is sent, the converter returns a frame-sync bit ahead of the data, and the block checks for that bit. The number of pulses, the edges on which bits are taken and the check of the sync bit all follow from these two choices.

The finished word is delivered with its channel number and a one-cycle valid pulse. If an expected sync bit is missing, the word is dropped and an error pulse is raised in its place.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset, wrN, rcN and csN are 1, dclk is 0, ready is 1, and wordValid and syncErr are 0.
- R2: addr carries the channel sampled with startReq. It stays unchanged while wrN is low and in the cycle in which wrN returns high. wrN is low for WR_CYC cycles, after addr has been driven for ADDR_CYC cycles.
- R3: A conversion is started by driving rcN low for at least CONV_CYC cycles, and csN is low whenever rcN is low.
- R4: With readAfter=1, no read pulse (dclk rising while rcN is high) occurs before busyN has been seen low and then high again. The word read is the result of the conversion this transaction started.
- R5: With readAfter=0, the burst starts as soon as busyN has been seen low after rcN fell. The word read is the result of the previous conversion, and the burst ends while busyN is still low.
- R6: With syncMode=0, exactly 17 read pulses follow rcN rising. Data bits 15 down to 0 are sampled at the rising edges of pulses 2 to 17.
- R7: With syncMode=1, exactly one arming pulse is sent while rcN and csN are both low. It is followed by exactly 18 read pulses. syncIn is checked at the rising edge of pulse 2, and data bits 15 down to 0 are sampled at the rising edges of pulses 3 to 18.
- R8: dclk is 0 whenever the block is idle (ready=1).
- R9: At least SETUP_CYC cycles pass between rcN rising and the first read pulse.
- R10: Each dclk high phase lasts exactly HALF_CYC cycles. Each low phase between two read pulses lasts exactly HALF_CYC cycles.
- R11: With syncMode=1, if syncIn is 0 at the rising edge of pulse 2, the word is discarded. syncErr pulses for one cycle and wordValid stays 0. syncErr and wordValid are never high together.
- R12: A completed word is presented on wordData with its channel on wordChan. wordValid is high for exactly one cycle, ready is high in that cycle, and a startReq in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start one transaction; taken while ready=1 |
| chanSel | input | 2 | Channel to convert, sampled with startReq |
| readAfter | input | 1 | 1: read the current result after BUSY; 0: read the previous result during BUSY |
| syncMode | input | 1 | 1: send an arming pulse and expect a sync bit |
| busyN | input | 1 | Converter BUSY, low while converting |
| syncIn | input | 1 | Converter frame-sync output |
| dataIn | input | 1 | Converter serial data output |
| addr | output | 2 | Multiplexer address to the converter |
| wrN | output | 1 | Address write strobe, active low |
| rcN | output | 1 | Read/convert control, low starts a conversion |
| csN | output | 1 | Chip select, active low |
| dclk | output | 1 | Gated data clock to the converter |
| ready | output | 1 | Idle and able to take startReq |
| wordValid | output | 1 | One-cycle strobe for a delivered word |
| wordData | output | 16 | Captured word, MSB first on the wire |
| wordChan | output | 2 | Channel of the delivered word |
| syncErr | output | 1 | One-cycle strobe: sync bit missing, word dropped |

## Verification
The cycle in which a finished word is delivered is also the cycle in which the controller is idle again. That makes it the cycle in which the next start request can be taken. The bench watches for wordValid and raises startReq in that same cycle. It then checks that the delivered word and channel are intact and that the next transaction, with a different channel and a different sync mode, runs with the correct pulse counts and data. A second overlap comes from sweeping the converter model's conversion length. This makes BUSY return high before, during and after the setup wait that follows rcN rising, and the pulse counts and the current-result word are checked in every case.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_WR, S_HOLD, S_CONV, S_ARM, S_SETUP, S_WAIT, S_BURST, S_DONE
  } rdState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;       // take channel and modes
    logic capture;    // shift in one data bit
    logic checkSync;  // test the frame-sync bit
    logic deliver;    // present the word or the error
  } rdStrobe_t;

endpackage

// File: rtl/rd_ctrl.sv
module rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int HALF_CYC  = 2,
  parameter int CONV_CYC  = 3,
  parameter int SETUP_CYC = 2,
  parameter int ADDR_CYC  = 1,
  parameter int WR_CYC    = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      busyN,
  input  logic      modeAfter,
  input  logic      syncMode,
  output logic      wrN,
  output logic      rcN,
  output logic      csN,
  output logic      dclk,
  output logic      ready,
  output rdStrobe_t strb
);
  localparam int M1 = (CONV_CYC > SETUP_CYC) ? CONV_CYC : SETUP_CYC;
  localparam int M2 = (M1 > HALF_CYC) ? M1 : HALF_CYC;
  localparam int M3 = (M2 > ADDR_CYC) ? M2 : ADDR_CYC;
  localparam int M4 = (M3 > WR_CYC) ? M3 : WR_CYC;
  localparam int TMR_W = $clog2(M4 + 1);
  localparam int PULSE_W = $clog2(DATA_W + 3);

  rdState_t state;
  logic [TMR_W-1:0] tmr;
  logic [PULSE_W-1:0] pulseNum, nextPulse, pulseTotal, firstData;
  logic sawLow, riseNow, lastPulse, busyGo;

  always_comb begin
    pulseTotal = syncMode ? PULSE_W'(DATA_W + 2) : PULSE_W'(DATA_W + 1);
    firstData  = syncMode ? PULSE_W'(3) : PULSE_W'(2);
    nextPulse  = pulseNum + PULSE_W'(1);
    lastPulse  = (pulseNum == pulseTotal);
    riseNow    = (state == S_BURST) && !dclk && (tmr == '0);
    busyGo     = modeAfter ? (sawLow && busyN) : (sawLow || !busyN);
    strb.load      = (state == S_IDLE) && startReq;
    strb.capture   = riseNow && (nextPulse >= firstData) && (nextPulse <= pulseTotal);
    strb.checkSync = riseNow && syncMode && (nextPulse == PULSE_W'(2));
    strb.deliver   = (state == S_DONE);
    ready          = (state == S_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      tmr      <= '0;
      pulseNum <= '0;
      sawLow   <= 1'b0;
      wrN      <= 1'b1;
      rcN      <= 1'b1;
      csN      <= 1'b1;
      dclk     <= 1'b0;
    end else begin
      if (state == S_IDLE) sawLow <= 1'b0;
      else if (!busyN)     sawLow <= 1'b1;

      case (state)
        S_IDLE: if (startReq) begin
          state    <= S_ADDR;
          tmr      <= TMR_W'(ADDR_CYC - 1);
          csN      <= 1'b0;
          pulseNum <= '0;
        end
        S_ADDR: if (tmr != '0) tmr <= tmr - 1'b1;
        else begin
          state <= S_WR;
          wrN   <= 1'b0;
          tmr   <= TMR_W'(WR_CYC - 1);
        end
        S_WR: if (tmr != '0) tmr <= tmr - 1'b1;
        else begin
          state <= S_HOLD;
          wrN   <= 1'b1;
          tmr   <= TMR_W'(ADDR_CYC - 1);
        end
        S_HOLD: if (tmr != '0) tmr <= tmr - 1'b1;
        else begin
          state <= S_CONV;
          rcN   <= 1'b0;
          tmr   <= TMR_W'(CONV_CYC - 1);
        end
        S_CONV: if (tmr != '0) tmr <= tmr - 1'b1;
        else if (syncMode) begin
          state <= S_ARM;
          dclk  <= 1'b1;
          tmr   <= TMR_W'(HALF_CYC - 1);
        end else begin
          state <= S_SETUP;
          rcN   <= 1'b1;
          tmr   <= TMR_W'(SETUP_CYC - 1);
        end
        S_ARM: if (tmr != '0) tmr <= tmr - 1'b1;
        else if (dclk) begin
          dclk <= 1'b0;
          tmr  <= TMR_W'(HALF_CYC - 1);
        end else begin
          state <= S_SETUP;
          rcN   <= 1'b1;
          tmr   <= TMR_W'(SETUP_CYC - 1);
        end
        S_SETUP: if (tmr != '0) tmr <= tmr - 1'b1;
        else state <= S_WAIT;
        S_WAIT: if (busyGo) begin
          state <= S_BURST;
          tmr   <= '0;
        end
        S_BURST: if (tmr != '0) tmr <= tmr - 1'b1;
        else if (!dclk) begin
          dclk     <= 1'b1;
          pulseNum <= nextPulse;
          tmr      <= TMR_W'(HALF_CYC - 1);
        end else begin
          dclk <= 1'b0;
          tmr  <= TMR_W'(HALF_CYC - 1);
          if (lastPulse) state <= S_DONE;
        end
        S_DONE: begin
          csN   <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rd_data.sv
module rd_data
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strb,
  input  logic [CH_W-1:0]   chanSel,
  input  logic              readAfter,
  input  logic              syncMode,
  input  logic              dataIn,
  input  logic              syncIn,
  output logic [CH_W-1:0]   chanQ,
  output logic              afterQ,
  output logic              syncQ,
  output logic [DATA_W-1:0] wordData,
  output logic [CH_W-1:0]   wordChan,
  output logic              wordValid,
  output logic              syncErr
);
  logic [DATA_W-1:0] shiftQ;
  logic              syncBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanQ     <= '0;
      afterQ    <= 1'b0;
      syncQ     <= 1'b0;
      shiftQ    <= '0;
      syncBad   <= 1'b0;
      wordData  <= '0;
      wordChan  <= '0;
      wordValid <= 1'b0;
      syncErr   <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      syncErr   <= 1'b0;
      if (strb.load) begin
        chanQ   <= chanSel;
        afterQ  <= readAfter;
        syncQ   <= syncMode;
        syncBad <= 1'b0;
      end
      if (strb.capture)
        shiftQ <= {shiftQ[DATA_W-2:0], dataIn};
      if (strb.checkSync && !syncIn)
        syncBad <= 1'b1;
      if (strb.deliver) begin
        if (syncQ && syncBad) syncErr <= 1'b1;
        else begin
          wordValid <= 1'b1;
          wordData  <= shiftQ;
          wordChan  <= chanQ;
        end
      end
    end
  end
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CH_W      = 2,
  parameter int HALF_CYC  = 2,
  parameter int CONV_CYC  = 3,
  parameter int SETUP_CYC = 2,
  parameter int ADDR_CYC  = 1,
  parameter int WR_CYC    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CH_W-1:0]   chanSel,
  input  logic              readAfter,
  input  logic              syncMode,
  input  logic              busyN,
  input  logic              syncIn,
  input  logic              dataIn,
  output logic [CH_W-1:0]   addr,
  output logic              wrN,
  output logic              rcN,
  output logic              csN,
  output logic              dclk,
  output logic              ready,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic [CH_W-1:0]   wordChan,
  output logic              syncErr
);
  rdStrobe_t       strb;
  logic [CH_W-1:0] chanQ;
  logic            afterQ, syncQ;

  rd_ctrl #(
    .DATA_W(DATA_W), .HALF_CYC(HALF_CYC), .CONV_CYC(CONV_CYC),
    .SETUP_CYC(SETUP_CYC), .ADDR_CYC(ADDR_CYC), .WR_CYC(WR_CYC)
  ) seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .busyN(busyN),
    .modeAfter(afterQ), .syncMode(syncQ),
    .wrN(wrN), .rcN(rcN), .csN(csN), .dclk(dclk), .ready(ready), .strb(strb)
  );

  rd_data #(.DATA_W(DATA_W), .CH_W(CH_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .chanSel(chanSel),
    .readAfter(readAfter), .syncMode(syncMode), .dataIn(dataIn), .syncIn(syncIn),
    .chanQ(chanQ), .afterQ(afterQ), .syncQ(syncQ),
    .wordData(wordData), .wordChan(wordChan), .wordValid(wordValid), .syncErr(syncErr)
  );

  assign addr = chanQ;
endmodule

// File: rtl/adc_readout_chk.sv
module adc_readout_chk #(
  parameter int CH_W      = 2,
  parameter int HALF_CYC  = 2,
  parameter int CONV_CYC  = 3,
  parameter int SETUP_CYC = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic [CH_W-1:0] addr,
  input logic            wrN,
  input logic            rcN,
  input logic            csN,
  input logic            dclk,
  input logic            busyN,
  input logic            ready,
  input logic            wordValid,
  input logic            syncErr,
  input logic            modeAfter,
  input logic            syncMode
);
  logic [7:0] rcLowRun, rcHighRun, clkHighRun, clkLowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rcLowRun   <= '0;
      rcHighRun  <= '0;
      clkHighRun <= '0;
      clkLowRun  <= '0;
    end else begin
      rcLowRun   <= rcN  ? 8'd0 : (rcLowRun   == 8'hFF ? rcLowRun   : rcLowRun + 8'd1);
      rcHighRun  <= !rcN ? 8'd0 : (rcHighRun  == 8'hFF ? rcHighRun  : rcHighRun + 8'd1);
      clkHighRun <= !dclk ? 8'd0 : (clkHighRun == 8'hFF ? clkHighRun : clkHighRun + 8'd1);
      clkLowRun  <= dclk ? 8'd0 : (clkLowRun  == 8'hFF ? clkLowRun  : clkLowRun + 8'd1);
    end
  end

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN || $rose(wrN)) |-> $stable(addr));
  assert_conv_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rcN) |-> (rcLowRun >= 8'(CONV_CYC)));
  assert_cs_with_rc_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rcN |-> !csN);
  assert_no_read_in_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dclk) && rcN && modeAfter) |-> busyN);
  assert_arm_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dclk) && !rcN) |-> (!csN && syncMode));
  assert_idle_clock_R8: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !dclk);
  assert_setup_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dclk) && rcN) |-> (rcHighRun >= 8'(SETUP_CYC)));
  assert_high_phase_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dclk) |-> (clkHighRun == 8'(HALF_CYC)));
  assert_low_phase_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dclk) |-> (clkLowRun >= 8'(HALF_CYC)));
  assert_err_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(wordValid && syncErr));
  assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
endmodule

bind adc_readout_ctrl adc_readout_chk #(
  .CH_W(CH_W), .HALF_CYC(HALF_CYC), .CONV_CYC(CONV_CYC), .SETUP_CYC(SETUP_CYC)
) chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrN(wrN), .rcN(rcN), .csN(csN),
  .dclk(dclk), .busyN(busyN), .ready(ready), .wordValid(wordValid),
  .syncErr(syncErr), .modeAfter(afterQ), .syncMode(syncQ)
);

// File: tb/adc_readout_ctrl_test.sv
`timescale 1ns/1ps
module adc_readout_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [1:0] chanSel = '0;
  logic readAfter = 1'b0, syncMode = 1'b0;
  logic busyN = 1'b1, syncIn = 1'b0, dataIn = 1'b0;
  logic [1:0] addr, wordChan;
  logic wrN, rcN, csN, dclk, ready, wordValid, syncErr;
  logic [15:0] wordData;

  int total = 0, bad = 0, cycles = 0;

  always #10 clk = ~clk;

  adc_readout_ctrl uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanSel(chanSel),
    .readAfter(readAfter), .syncMode(syncMode), .busyN(busyN), .syncIn(syncIn),
    .dataIn(dataIn), .addr(addr), .wrN(wrN), .rcN(rcN), .csN(csN), .dclk(dclk),
    .ready(ready), .wordValid(wordValid), .wordData(wordData), .wordChan(wordChan),
    .syncErr(syncErr)
  );

  function automatic logic [15:0] convVal(int n, int c);
    return 16'((n * 16'h2F1B) ^ (c << 14) ^ 16'h5A5A);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // converter model and monitor, evaluated away from the active edge
  int convLen = 10;
  bit syncKill = 0;
  int mdlConv = 0, busyLeft = 0, mdlChan = 0, convChan = 0;
  logic [15:0] mdlResult = '0, shiftWord = '0;
  bit armed = 0;
  int pIdx = 0, armCnt = 0, readCnt = 0, lowRun = 0, rcLowSeen = 0;
  int sinceRc = 0, setupSeen = -1, run = 0, minHigh = 99, minLow = 99, idleBad = 0;
  logic prevRc = 1, prevDclk = 0, prevWr = 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (wrN && !prevWr) mdlChan = int'(addr);
      if (!rcN && prevRc && !csN && busyN) begin
        mdlConv++; convChan = mdlChan; busyLeft = convLen; busyN = 0; armed = 0;
      end else if (!busyN) begin
        if (busyLeft <= 1) begin busyN = 1; mdlResult = convVal(mdlConv, convChan); end
        else busyLeft--;
      end
      if (!rcN) lowRun++;
      else begin
        if (!prevRc) begin rcLowSeen = lowRun; pIdx = 0; sinceRc = 0; setupSeen = -1; end
        else sinceRc++;
        lowRun = 0;
      end
      if (dclk && !prevDclk) begin
        if (!rcN && !csN) begin armCnt++; armed = !syncKill; end
        else begin
          int bp;
          readCnt++; pIdx++;
          if (pIdx == 1) begin shiftWord = mdlResult; if (setupSeen < 0) setupSeen = sinceRc; end
          syncIn = armed && (pIdx == 1);
          bp = armed ? pIdx - 1 : pIdx;
          dataIn = (bp >= 1 && bp <= 16) ? shiftWord[16 - bp] : 1'b0;
        end
      end
      if (dclk != prevDclk) begin
        if (rcN) begin
          if (prevDclk) begin if (run < minHigh) minHigh = run; end
          else if (pIdx > 1 && run < minLow) minLow = run;
        end
        run = 0;
      end
      run++;
      if (ready && dclk) idleBad++;
      prevRc = rcN; prevDclk = dclk; prevWr = wrN;
    end
  end

  int txN = 0;
  logic [15:0] lastRes = '0;

  task automatic runOne(bit after, bit sync, int chan, int len, bit kill, int gap);
    logic [15:0] exp;
    bit got = 0;
    repeat (gap) @(negedge clk);
    armCnt = 0; readCnt = 0; minHigh = 99; minLow = 99; setupSeen = -1;
    convLen = len; syncKill = kill;
    readAfter = after; syncMode = sync; chanSel = 2'(chan); startReq = 1;
    @(negedge clk); startReq = 0;
    txN++;
    exp = after ? convVal(txN, chan) : lastRes;
    lastRes = convVal(txN, chan);
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (wordValid || syncErr) got = 1;
    end
    check(got == 1, "R12", "transaction completed", got, 1);
    check(mdlChan == chan, "R2", "channel latched by write strobe", mdlChan, chan);
    check(rcLowSeen >= 3, "R3", "read/convert low width", rcLowSeen, 3);
    check(armCnt == (sync ? 1 : 0), sync ? "R7" : "R6", "arming pulses", armCnt, sync ? 1 : 0);
    check(readCnt == (sync ? 18 : 17), sync ? "R7" : "R6", "read pulses", readCnt, sync ? 18 : 17);
    check(setupSeen >= 2, "R9", "setup after read/convert rise", setupSeen, 2);
    check(minHigh == 2 && minLow == 2, "R10", "clock phase width", minHigh * 100 + minLow, 202);
    if (kill) begin
      check(syncErr && !wordValid, "R11", "missing sync drops word", {syncErr, wordValid}, 2);
    end else begin
      check(wordValid && !syncErr, "R12", "valid without error", {wordValid, syncErr}, 2);
      check(wordData == exp, after ? "R4" : "R5", "word value", wordData, exp);
      check(wordChan == 2'(chan), "R12", "word channel", wordChan, chan);
      check(ready == 1, "R12", "ready with valid", ready, 1);
      if (!after) check(busyN == 0, "R5", "burst inside conversion", busyN, 0);
    end
  endtask

  task automatic waitIdle();
    while (!busyN || !ready) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wrN && rcN && csN && !dclk, "R1", "strobes idle in reset", {wrN, rcN, csN, dclk}, 14);
    check(ready && !wordValid && !syncErr, "R1", "status idle in reset", {ready, wordValid, syncErr}, 4);
    rstN = 1;
    @(negedge clk);
    check(wrN && rcN && csN && !dclk && ready, "R1", "idle after reset", {wrN, rcN, csN, dclk, ready}, 29);

    for (int a = 0; a < 2; a++)
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 4; c++)
          for (int l = 0; l < 3; l++) begin
            int len;
            if (a == 1) len = (l == 0) ? 1 : (l == 1) ? 6 : 150;
            else        len = (l == 0) ? 200 : (l == 1) ? 230 : 260;
            runOne(a[0], s[0], c, len, 0, 2);
            waitIdle();
          end

    // missing sync bit, both read timings (R11)
    runOne(1, 1, 3, 8, 1, 2);   waitIdle();
    runOne(0, 1, 1, 220, 1, 2); waitIdle();

    // start taken in the same cycle the previous word is delivered (R12)
    runOne(1, 0, 2, 6, 0, 2);
    runOne(1, 1, 1, 6, 0, 0);
    waitIdle();
    runOne(1, 1, 0, 4, 0, 0);
    waitIdle();

    check(idleBad == 0, "R8", "clock quiet while idle", idleBad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule